// File: doc/BRIEF.md
# LRU Recency List Tracker

This block keeps a set of resident page identifiers in recency order. Slot 0 of a shifting register array always holds the least recently used identifier, and the highest occupied slot holds the most recently used one. Each reference is a valid strobe with an identifier. A reference that is already present moves to the tail. A reference that is absent is appended at the tail. When the list is full, the absent reference pushes the head out, and the head is announced as the victim.

Each reference is handled in one cycle. A hit flag and an eviction report are registered and appear the cycle after the strobe. A query port shows the current head, and an occupancy count is given. Fetching pages, updating tables and handling faults are left to the surrounding logic.

Top module: `lru_order_list`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, empties the list. After it, `count` is 0, `head_valid` is 0, and `hit` and `evict_valid` are 0.
- R2: A reference whose identifier is absent while `count` < DEPTH appends the identifier at the tail and raises `count` by one. It never raises `evict_valid`.
- R3: A reference whose identifier is absent while `count` == DEPTH ejects the head. `evict_valid` is raised, `evict_id` equals the previous head, and `count` stays at DEPTH. The new identifier becomes the tail.
- R4: A reference whose identifier is present moves that entry to the tail. All other entries keep their relative order, `count` is unchanged, and `hit` is raised with no eviction.
- R5: `head_id` always shows the least recently used entry, which is the entry referenced longest ago. `head_valid` is 1 exactly when `count` is nonzero. Both follow the list state with no extra delay.
- R6: `hit`, `evict_valid` and `evict_id` are registered and valid in the cycle after the strobe. In any cycle after a clock edge with no strobe, `hit` and `evict_valid` are 0.
- R7: `hit` and `evict_valid` are never 1 together, and `count` never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_valid | input | 1 | Reference strobe |
| ref_id | input | ID_W | Referenced identifier |
| hit | output | 1 | Previous reference was present |
| evict_valid | output | 1 | Previous reference ejected the head |
| evict_id | output | ID_W | Ejected identifier |
| count | output | $clog2(DEPTH+1) | Current occupancy |
| head_id | output | ID_W | Least recently used identifier |
| head_valid | output | 1 | List not empty |

## Verification
A strobe that is sampled at a rising edge has every effect visible after that same edge. `hit`, `evict_valid`, `evict_id`, `count` and the head port all change together, one register stage behind the strobe. The bench drives each reference on a falling edge and compares against its own queue model on the next falling edge. Idle cycles are checked at the falling edge that follows a strobe-free rising edge, so that the registered flags are seen to drop back to zero.

// File: rtl/lru_order_list.sv
module lru_order_list #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_valid,
  input  logic [ID_W-1:0]  ref_id,
  output logic             hit,
  output logic             evict_valid,
  output logic [ID_W-1:0]  evict_id,
  output logic [CNT_W-1:0] count,
  output logic [ID_W-1:0]  head_id,
  output logic             head_valid
);

  logic [ID_W-1:0]  slot_q [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [DEPTH-1:0] match;
  logic [CNT_W-1:0] match_pos;
  logic [CNT_W-1:0] tail_pos;
  logic             found, full;
  logic             hit_q, ev_q;
  logic [ID_W-1:0]  evid_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = (CNT_W'(i) < count_q) && (slot_q[i] == ref_id);
  end

  always_comb begin
    match_pos = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (match[i]) match_pos = CNT_W'(i);
  end

  assign found    = |match;
  assign full     = (count_q == CNT_W'(DEPTH));
  assign tail_pos = found ? count_q - CNT_W'(1) : (full ? CNT_W'(DEPTH - 1) : count_q);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift_i;
    assign shift_i = found ? (CNT_W'(i) >= match_pos && CNT_W'(i) < count_q) : full;
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[i] <= '0;
      end else if (ref_valid) begin
        if (tail_pos == CNT_W'(i))
          slot_q[i] <= ref_id;
        else if (shift_i) begin
          if (i < DEPTH - 1) slot_q[i] <= slot_q[(i < DEPTH - 1) ? i + 1 : i];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      hit_q   <= 1'b0;
      ev_q    <= 1'b0;
      evid_q  <= '0;
    end else begin
      hit_q <= ref_valid && found;
      ev_q  <= ref_valid && !found && full;
      if (ref_valid && !found && full) evid_q <= slot_q[0];
      if (ref_valid && !found && !full) count_q <= count_q + CNT_W'(1);
    end
  end

  assign hit         = hit_q;
  assign evict_valid = ev_q;
  assign evict_id    = evid_q;
  assign count       = count_q;
  assign head_id     = slot_q[0];
  assign head_valid  = (count_q != '0);

endmodule

module lru_order_list_chk #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_valid,
  input logic             hit,
  input logic             evict_valid,
  input logic [ID_W-1:0]  evict_id,
  input logic [CNT_W-1:0] count,
  input logic [ID_W-1:0]  head_id,
  input logic             head_valid
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  assert_reset_empty_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && !hit && !evict_valid));

  assert_append_grows_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(ref_valid) && !hit && $past(count) < CNT_W'(DEPTH)) |-> (count == $past(count) + CNT_W'(1) && !evict_valid));

  assert_evict_head_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    evict_valid |-> (evict_id == $past(head_id) && $past(count) == CNT_W'(DEPTH) && count == CNT_W'(DEPTH)));

  assert_hit_keeps_count_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    hit |-> (count == $past(count)));

  assert_head_flag_R5: assert property (@(posedge clk) disable iff (rst)
    head_valid == (count != '0));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(ref_valid) |-> (!hit && !evict_valid && $stable(count)));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (count <= CNT_W'(DEPTH)) && !(hit && evict_valid));
endmodule

bind lru_order_list lru_order_list_chk #(.DEPTH(DEPTH), .ID_W(ID_W)) chk_i (
  .clk(clk), .rst(rst), .ref_valid(ref_valid), .hit(hit),
  .evict_valid(evict_valid), .evict_id(evict_id), .count(count),
  .head_id(head_id), .head_valid(head_valid)
);

// File: tb/lru_order_list_tb_top.sv
`timescale 1ns/1ps
module lru_order_list_tb_top;
  localparam int DEPTH = 8;
  localparam int ID_W  = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1, ref_valid = 0;
  logic [ID_W-1:0] ref_id = '0;
  logic hit, evict_valid, head_valid;
  logic [ID_W-1:0] evict_id, head_id;
  logic [CNT_W-1:0] count;

  int checks = 0, errors = 0, cycles = 0;
  int mq [DEPTH];
  int mlen = 0;
  int seed = 7;

  always #4 clk = ~clk;

  lru_order_list #(.DEPTH(DEPTH), .ID_W(ID_W)) dut_i (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_id(ref_id),
    .hit(hit), .evict_valid(evict_valid), .evict_id(evict_id),
    .count(count), .head_id(head_id), .head_valid(head_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_head();
    chk("R5 head_valid", int'(head_valid), (mlen != 0) ? 1 : 0);
    if (mlen != 0) chk("R5 head_id", int'(head_id), mq[0]);
  endtask

  task automatic do_ref(input int id);
    int pos = -1;
    int e_hit = 0, e_ev = 0, e_vid = 0;
    for (int i = 0; i < mlen; i++) if (mq[i] == id) pos = i;
    if (pos >= 0) begin
      e_hit = 1;
      for (int i = pos; i < mlen - 1; i++) mq[i] = mq[i + 1];
      mq[mlen - 1] = id;
    end else if (mlen < DEPTH) begin
      mq[mlen] = id;
      mlen++;
    end else begin
      e_ev = 1;
      e_vid = mq[0];
      for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i + 1];
      mq[DEPTH - 1] = id;
    end
    ref_valid = 1;
    ref_id = ID_W'(id);
    @(negedge clk);
    ref_valid = 0;
    if (e_hit == 1) chk("R4 hit", int'(hit), 1);
    else chk("R2 hit", int'(hit), 0);
    if (e_ev == 1) begin
      chk("R3 evict_valid", int'(evict_valid), 1);
      chk("R3 evict_id", int'(evict_id), e_vid);
    end else chk("R2 evict_valid", int'(evict_valid), 0);
    chk("R7 count", int'(count), mlen);
    chk_head();
  endtask

  task automatic idle();
    @(negedge clk);
    chk("R6 idle hit", int'(hit), 0);
    chk("R6 idle evict", int'(evict_valid), 0);
    chk("R6 idle count", int'(count), mlen);
  endtask

  task automatic do_reset();
    rst = 1;
    @(negedge clk);
    rst = 0;
    mlen = 0;
    chk("R1 count", int'(count), 0);
    chk("R1 head_valid", int'(head_valid), 0);
    chk("R1 hit", int'(hit), 0);
    chk("R1 evict", int'(evict_valid), 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: fill below capacity
    for (int i = 0; i < DEPTH; i++) do_ref(10 + i);
    idle();
    // R4: hit every position, exhaustive over index
    for (int p = 0; p < DEPTH; p++) do_ref(mq[p]);
    do_ref(mq[DEPTH - 1]);
    idle();
    // R3: evict a full round
    for (int i = 0; i < DEPTH + 2; i++) do_ref(40 + i);
    // R4 at each fill level then R1 mid-run
    for (int fill = 1; fill <= DEPTH; fill++) begin
      do_reset();
      for (int i = 0; i < fill; i++) do_ref(i);
      for (int p = 0; p < fill; p++) do_ref(mq[fill - 1 - p]);
      do_ref(100);
      idle();
    end
    // mixed sweep over a small identifier range
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      do_ref((seed >> 8) % 12);
      if ((seed & 15) == 0) idle();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule